// File: doc/BRIEF.md
# Masked Vector Gather-Scatter Unit

This block is the memory access engine of a 16-lane vector engine. One operation carries a per-lane address for every lane, a 16-bit predicate and, for a store, one data element per lane. Since each lane may point anywhere in memory, the unit does not issue a burst. It walks the lanes whose predicate bit is set, from lane 0 upward. It issues one single-element access per lane on a plain single-port request/ready memory port, and it matches read responses back to their lanes in the order it issued them.

A gather (vector load) merges the returned elements into a destination vector register kept inside the unit. Lanes that are predicated off keep their old contents, so if-then-else code can be built from two masked operations. A scatter (vector store) writes the lane elements out. When two active lanes share an address, the higher lane writes last and its value is the one that remains. Each operation selects an element width of 64 bits, or 32 bits held zero-extended in a 64-bit slot. A busy flag spans the whole operation, and a one-cycle done pulse closes it.

Top module: `vec_gather_scatter`

## Requirements
- R1: After reset, busy, done and memReq are 0 and every destination lane reads 0.
- R2: Only lanes whose laneMask bit is 1 produce a memory request. Requests go out in ascending lane order, one per cycle in which memReady is high. Each request carries its lane's address taken from laneAddr bits [16*i +: 16], and memWe equals opStore.
- R3: On a gather (opStore=0), each active lane i receives the element read from its address in dstVec bits [64*i +: 64]. Every inactive lane keeps its previous value.
- R4: On a scatter (opStore=1), each active lane writes memWdata taken from laneData bits [64*i +: 64]. When active lanes share an address, the highest such lane's data is written last.
- R5: If laneMask is all zeros, done is high in the first cycle after start is sampled and no memory request is made.
- R6: A start that arrives while busy is high is ignored and has no effect on the operation in flight.
- R7: busy rises only in the cycle after start is sampled and stays high through the cycle in which done is high. done is a single-cycle pulse, and both are low on the cycle after done.
- R8: With opWide=0 (32-bit elements), scatter write data have bits [63:32] cleared and gathered lanes are stored with bits [63:32] cleared. With opWide=1, all 64 bits pass through.
- R9: While memReq is high and memReady is low, memReq, memAddr, memWe and memWdata hold their values into the next cycle.
- R10: Read responses, flagged by memRvalid, are taken in request order, so that the n-th response lands in the lane of the n-th read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| opStore | input | 1 | 1 = scatter, 0 = gather |
| opWide | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| laneMask | input | 16 | Per-lane predicate, bit i enables lane i |
| laneAddr | input | 256 | Lane addresses, lane i at [16*i +: 16] |
| laneData | input | 1024 | Scatter data, lane i at [64*i +: 64] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dstVec | output | 1024 | Destination vector register, lane i at [64*i +: 64] |
| memReq | output | 1 | Memory access request |
| memAddr | output | 16 | Access address |
| memWe | output | 1 | 1 = write, 0 = read |
| memWdata | output | 64 | Write data |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRvalid | input | 1 | Read response valid |
| memRdata | input | 64 | Read response data |

## Verification
During a gather, the unit can issue the request for one lane in the same clock edge that it retires the response of an earlier lane. The lane-tag queue is then pushed and popped at once, and the destination register is written while the pending set shrinks. The bench memory answers every accepted read on the following cycle and drives memReady with rotating stall patterns, so many of these edges carry both events. It also produces the case where a stall lets the queue drain first. The result is judged by comparing every destination lane with the value the bench predicts from its own copy of memory, and the request log with the expected ascending lane order.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vgsState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;    // capture operands, start lane walk
    logic active;  // lane walk running, request may be shown
    logic issue;   // current lane request accepted this cycle
    logic retire;  // read response arrives this cycle
  } vgsStrobe_t;

endpackage

// File: rtl/vgs_lane_pick.sv
module vgs_lane_pick #(
  parameter int LANES = 16,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] pend,
  output logic [LW-1:0]    lane,
  output logic [LANES-1:0] oneHot,
  output logic             any
);

  // Lowest pending lane wins, giving ascending issue order.
  always_comb begin
    lane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) lane = LW'(i);
    end
  end

  assign oneHot = pend & (~pend + LANES'(1));
  assign any    = |pend;

endmodule

// File: rtl/vgs_tag_fifo.sv
module vgs_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [TAG_W-1:0] pushTag,
  input  logic             pop,
  output logic [TAG_W-1:0] popTag,
  output logic [CW-1:0]    count
);

  logic [TAG_W-1:0] tagQ [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) tagQ[wrPtr] <= pushTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign popTag = tagQ[rdPtr];

endmodule

// File: rtl/vgs_datapath.sv
module vgs_datapath
  import vgs_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  vgsStrobe_t              strobe,
  input  logic [LANES-1:0]        startMask,
  input  logic                    startStore,
  input  logic                    startWide,
  input  logic [LANES*ADDR_W-1:0] addrVec,
  input  logic [LANES*DATA_W-1:0] dataVec,
  input  logic [DATA_W-1:0]       memRdata,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memWe,
  output logic [DATA_W-1:0]       memWdata,
  output logic                    pendEmpty,
  output logic                    drained,
  output logic [LANES*DATA_W-1:0] dstVec
);

  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CW   = $clog2(LANES + 1);
  localparam int HALF = DATA_W / 2;

  logic [LANES-1:0]  pendQ;
  logic              storeQ;
  logic              wideQ;
  logic [ADDR_W-1:0] addrQ [LANES];
  logic [DATA_W-1:0] dataQ [LANES];
  logic [DATA_W-1:0] dstQ  [LANES];

  logic [LW-1:0]     curLane;
  logic [LANES-1:0]  curHot;
  logic              anyPend;
  logic [LW-1:0]     popTag;
  logic [CW-1:0]     outCnt;
  logic              pushTag;

  function automatic logic [DATA_W-1:0] trimElem(input logic [DATA_W-1:0] v,
                                                 input logic w);
    trimElem = w ? v : {{(DATA_W - HALF){1'b0}}, v[HALF-1:0]};
  endfunction

  vgs_lane_pick #(.LANES(LANES)) u_pick (
    .pend   (pendQ),
    .lane   (curLane),
    .oneHot (curHot),
    .any    (anyPend)
  );

  assign pushTag = strobe.issue & ~storeQ;

  vgs_tag_fifo #(.DEPTH(LANES), .TAG_W(LW)) u_tags (
    .clk     (clk),
    .rstN    (rstN),
    .push    (pushTag),
    .pushTag (curLane),
    .pop     (strobe.retire),
    .popTag  (popTag),
    .count   (outCnt)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      storeQ <= 1'b0;
      wideQ  <= 1'b1;
      for (int i = 0; i < LANES; i++) begin
        addrQ[i] <= '0;
        dataQ[i] <= '0;
        dstQ[i]  <= '0;
      end
    end else begin
      if (strobe.load) begin
        pendQ  <= startMask;
        storeQ <= startStore;
        wideQ  <= startWide;
        for (int i = 0; i < LANES; i++) begin
          addrQ[i] <= addrVec[i*ADDR_W +: ADDR_W];
          dataQ[i] <= dataVec[i*DATA_W +: DATA_W];
        end
      end else if (strobe.issue) begin
        pendQ <= pendQ & ~curHot;
      end
      if (strobe.retire) dstQ[popTag] <= trimElem(memRdata, wideQ);
    end
  end

  assign memReq    = strobe.active & anyPend;
  assign memAddr   = addrQ[curLane];
  assign memWe     = storeQ;
  assign memWdata  = trimElem(dataQ[curLane], wideQ);
  assign pendEmpty = ~anyPend;
  assign drained   = ~anyPend & (outCnt == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_dst
    assign dstVec[g*DATA_W +: DATA_W] = dstQ[g];
  end

endmodule

// File: rtl/vgs_ctrl.sv
module vgs_ctrl
  import vgs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       maskZero,
  input  logic       memReady,
  input  logic       memRvalid,
  input  logic       pendEmpty,
  input  logic       drained,
  output vgsStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  vgsState_e state;
  vgsState_e stateNext;

  always_comb begin
    strobe.load   = (state == ST_IDLE) & start;
    strobe.active = (state == ST_RUN);
    strobe.issue  = (state == ST_RUN) & ~pendEmpty & memReady;
    strobe.retire = (state == ST_RUN) & memRvalid;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = maskZero ? ST_FIN : ST_RUN;
      ST_RUN:  if (drained) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/vec_gather_scatter.sv
module vec_gather_scatter
  import vgs_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    opStore,
  input  logic                    opWide,
  input  logic [LANES-1:0]        laneMask,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  input  logic [LANES*DATA_W-1:0] laneData,
  output logic                    busy,
  output logic                    done,
  output logic [LANES*DATA_W-1:0] dstVec,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memWe,
  output logic [DATA_W-1:0]       memWdata,
  input  logic                    memReady,
  input  logic                    memRvalid,
  input  logic [DATA_W-1:0]       memRdata
);

  vgsStrobe_t strobe;
  logic       pendEmpty;
  logic       drained;
  logic       maskZero;

  assign maskZero = ~|laneMask;

  vgs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .maskZero  (maskZero),
    .memReady  (memReady),
    .memRvalid (memRvalid),
    .pendEmpty (pendEmpty),
    .drained   (drained),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  vgs_datapath #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startMask  (laneMask),
    .startStore (opStore),
    .startWide  (opWide),
    .addrVec    (laneAddr),
    .dataVec    (laneData),
    .memRdata   (memRdata),
    .memReq     (memReq),
    .memAddr    (memAddr),
    .memWe      (memWe),
    .memWdata   (memWdata),
    .pendEmpty  (pendEmpty),
    .drained    (drained),
    .dstVec     (dstVec)
  );

endmodule

// File: rtl/vgs_checker.sv
module vgs_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic [DATA_W-1:0] memWdata
);

  // R9: a stalled request is held unchanged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: done only inside a busy window
  a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R7: busy begins only after a sampled start
  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R5: no memory traffic outside an operation
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  // R6: an operation in flight is not cut short by another start
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

bind vec_gather_scatter vgs_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_vgsChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .memReq   (memReq),
  .memReady (memReady),
  .memAddr  (memAddr),
  .memWe    (memWe),
  .memWdata (memWdata)
);

// File: tb/vec_gather_scatter_bench.sv
module vec_gather_scatter_bench;

  localparam int L  = 16;
  localparam int AW = 16;
  localparam int DW = 64;
  localparam int NCASE = 7;

  // {store, wide, mask[15:0], seed[7:0], readyPattern[7:0]}
  localparam logic [33:0] TBL [NCASE] = '{
    {1'b0, 1'b1, 16'hFFFF, 8'h01, 8'hFF},
    {1'b0, 1'b1, 16'hA5C3, 8'h22, 8'hB6},
    {1'b1, 1'b1, 16'h5A0F, 8'h13, 8'hFF},
    {1'b1, 1'b0, 16'hFFF0, 8'h44, 8'h9D},
    {1'b0, 1'b0, 16'h8001, 8'h13, 8'h6E},
    {1'b1, 1'b1, 16'h0F0F, 8'h07, 8'h55},
    {1'b0, 1'b1, 16'h3C3C, 8'h07, 8'h33}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic          opStore;
  logic          opWide;
  logic [L-1:0]  laneMask;
  logic [L*AW-1:0] laneAddr;
  logic [L*DW-1:0] laneData;
  logic          busy;
  logic          done;
  logic [L*DW-1:0] dstVec;
  logic          memReq;
  logic [AW-1:0] memAddr;
  logic          memWe;
  logic [DW-1:0] memWdata;
  logic          memReady;
  logic          memRvalid;
  logic [DW-1:0] memRdata;

  vec_gather_scatter u_vec_gather_scatter (
    .clk(clk), .rstN(rstN), .start(start), .opStore(opStore), .opWide(opWide),
    .laneMask(laneMask), .laneAddr(laneAddr), .laneData(laneData),
    .busy(busy), .done(done), .dstVec(dstVec),
    .memReq(memReq), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memReady(memReady), .memRvalid(memRvalid), .memRdata(memRdata)
  );

  always #5ns clk = ~clk;

  // ---------------- memory model ----------------
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  logic [7:0]    readyPat = 8'hFF;
  logic [2:0]    rotIdx;
  logic [AW-1:0] logAddr [512];
  logic          logWe   [512];
  logic [DW-1:0] logData [512];
  int            logN = 0;

  function automatic logic [DW-1:0] memInit(input int i);
    return {16'hF00D, 8'(i), ~8'(i), 32'(i) * 32'h0101_0101};
  endfunction

  function automatic logic [DW-1:0] dataOf(input logic [7:0] s, input int l);
    return {s, 8'(l), 16'hBEEF, 8'(l) ^ s, 24'h5A5A5A};
  endfunction

  function automatic logic [AW-1:0] addrOf(input logic [7:0] s, input int l, input bit dup);
    return dup ? 16'h0077 : {8'h00, 8'(32'(s) * 5 + l * 11)};
  endfunction

  function automatic logic [DW-1:0] trim(input logic [DW-1:0] v, input logic w);
    return w ? v : {32'h0, v[31:0]};
  endfunction

  assign memReady = readyPat[rotIdx];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= memInit(i);
      memRvalid <= 1'b0;
      memRdata  <= '0;
      rotIdx    <= '0;
    end else begin
      rotIdx    <= rotIdx + 3'd1;
      memRvalid <= 1'b0;
      if (memReq && memReady) begin
        if (memWe) mem[memAddr[7:0]] <= memWdata;
        else begin
          memRvalid <= 1'b1;
          memRdata  <= mem[memAddr[7:0]];
        end
        logAddr[logN[8:0]] <= memAddr;
        logWe[logN[8:0]]   <= memWe;
        logData[logN[8:0]] <= memWdata;
        logN <= logN + 1;
      end
    end
  end

  // R9 monitor: stalled request must be unchanged one cycle later
  int            holdFails = 0;
  logic          wasStall = 1'b0;
  logic [AW-1:0] sAddr;
  logic          sWe;
  logic [DW-1:0] sData;
  always @(negedge clk) begin
    if (rstN && wasStall &&
        !(memReq && memAddr == sAddr && memWe == sWe && memWdata == sData))
      holdFails <= holdFails + 1;
    wasStall <= rstN && memReq && !memReady;
    sAddr <= memAddr;
    sWe   <= memWe;
    sData <= memWdata;
  end

  // ---------------- checking ----------------
  int nChecks = 0;
  int nFail   = 0;
  logic [DW-1:0] dstExp [L];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic st, input logic wd, input logic [15:0] m,
                       input logic [7:0] seed, input bit dup,
                       output int base, output bit busyOk);
    int cyc;
    opStore  = st;
    opWide   = wd;
    laneMask = m;
    for (int l = 0; l < L; l++) begin
      laneAddr[l*AW +: AW] = addrOf(seed, l, dup);
      laneData[l*DW +: DW] = dataOf(seed, l);
    end
    base  = logN;
    start = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    busyOk = 1'b1;
    cyc    = 0;
    while (!done && cyc < 3000) begin
      if (!busy) busyOk = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (!done || !busy) busyOk = 1'b0;
    @(negedge clk);
    if (busy || done) busyOk = 1'b0;
  endtask

  // Apply expectations for a finished op and check order, data and results.
  task automatic judge(input logic st, input logic wd, input logic [15:0] m,
                       input logic [7:0] seed, input bit dup, input int base);
    int k;
    int bad;
    bad = 0;
    k   = base;
    for (int l = 0; l < L; l++) begin
      if (m[l]) begin
        if (logAddr[k[8:0]] != addrOf(seed, l, dup) || logWe[k[8:0]] != st) bad++;
        if (st && logData[k[8:0]] != trim(dataOf(seed, l), wd)) bad++;
        k++;
      end
    end
    chk(bad == 0 && (logN - base) == $countones(m), "R2 lane order/addresses",
        64'(logN - base), 64'($countones(m)));
    bad = 0;
    if (st) begin
      for (int l = 0; l < L; l++)
        if (m[l]) shadow[addrOf(seed, l, dup)] = trim(dataOf(seed, l), wd);
      for (int a = 0; a < 256; a++) if (mem[a] != shadow[a]) bad++;
      chk(bad == 0, wd ? "R4 scatter memory image" : "R8 narrow scatter memory image",
          64'(bad), 64'd0);
    end else begin
      for (int l = 0; l < L; l++)
        if (m[l]) dstExp[l] = trim(shadow[addrOf(seed, l, dup)], wd);
      for (int l = 0; l < L; l++) if (dstVec[l*DW +: DW] != dstExp[l]) bad++;
      chk(bad == 0, wd ? "R3 R10 gather merge" : "R8 narrow gather merge", 64'(bad), 64'd0);
    end
  endtask

  initial begin
    #2_000_000ns;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFail);
    $finish;
  end

  initial begin
    int  base;
    bit  busyOk;
    int  bad;
    rstN = 1'b0;
    start = 1'b0;
    opStore = 1'b0;
    opWide = 1'b1;
    laneMask = '0;
    laneAddr = '0;
    laneData = '0;
    for (int i = 0; i < 256; i++) shadow[i] = memInit(i);
    for (int l = 0; l < L; l++) dstExp[l] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !memReq, "R1 reset flags", {61'd0, busy, done, memReq}, 64'd0);
    chk(dstVec == '0, "R1 reset destination", dstVec[63:0], 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table-driven operations
    for (int t = 0; t < NCASE; t++) begin
      readyPat = TBL[t][7:0];
      runOp(TBL[t][33], TBL[t][32], TBL[t][31:16], TBL[t][15:8], 1'b0, base, busyOk);
      chk(busyOk, "R7 busy/done window", 64'(busyOk), 64'd1);
      judge(TBL[t][33], TBL[t][32], TBL[t][31:16], TBL[t][15:8], 1'b0, base);
    end

    // R5 empty mask: done next cycle, no traffic, destination untouched
    readyPat = 8'hFF;
    opStore  = 1'b0;
    laneMask = '0;
    base     = logN;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && busy, "R5 empty mask done timing", {62'd0, done, busy}, 64'd3);
    @(negedge clk);
    chk(!done && !busy && logN == base, "R5 empty mask no traffic", 64'(logN - base), 64'd0);
    bad = 0;
    for (int l = 0; l < L; l++) if (dstVec[l*DW +: DW] != dstExp[l]) bad++;
    chk(bad == 0, "R3 empty mask keeps destination", 64'(bad), 64'd0);

    // R6 start while busy is ignored
    readyPat = 8'hAA;
    opStore  = 1'b0;
    opWide   = 1'b1;
    laneMask = 16'hFFFF;
    for (int l = 0; l < L; l++) begin
      laneAddr[l*AW +: AW] = addrOf(8'h30, l, 1'b0);
      laneData[l*DW +: DW] = dataOf(8'h30, l);
    end
    base  = logN;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    opStore  = 1'b1;
    laneMask = 16'h0001;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    bad = 0;
    for (int k = base; k < logN; k++) if (logWe[k[8:0]]) bad++;
    chk(bad == 0 && (logN - base) == 16, "R6 second start ignored", 64'(logN - base), 64'd16);
    judge(1'b0, 1'b1, 16'hFFFF, 8'h30, 1'b0, base);

    // R4 all lanes on one address: highest lane remains
    readyPat = 8'hD3;
    runOp(1'b1, 1'b1, 16'hFFFF, 8'h5C, 1'b1, base, busyOk);
    chk(mem[8'h77] == dataOf(8'h5C, 15), "R4 duplicate address last lane wins",
        mem[8'h77], dataOf(8'h5C, 15));
    judge(1'b1, 1'b1, 16'hFFFF, 8'h5C, 1'b1, base);

    // R9 stalled requests held
    chk(holdFails == 0, "R9 request held under stall", 64'(holdFails), 64'd0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule